// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block sits between the CPU's operand path and its data RAM. The RAM is split into eight banks. For each access the block takes an 8-bit operand address and an access kind, and it returns three things: the physical RAM address, the RAM write enable, and a flag that says whether the offset lies in the shared special-register region. There are three kinds of access. A direct access uses the operand address as the offset in bank 0. The first indirect port dereferences pointer 0 and always stays in bank 0. The second indirect port dereferences pointer 1 or pointer 2, and it takes its bank from the bank pointer that pairs with the pointer in use.

The block owns the registers that feed this mapping: three 8-bit memory pointers, two 3-bit bank pointers and a control register whose top bit chooses the pointer pair. These registers live in special-register space, and any access whose resolved offset names them reads or writes them. The RAM array, the ALU and instruction decode sit outside the block. Fixed register offsets: indirect port 0 at 0x00, pointer 0 at 0x01, indirect port 1 at 0x02, pointer 1 at 0x03, pointer 2 at 0x04, bank pointer 1 at 0x05, bank pointer 2 at 0x06, control at 0x07.

Top module: `bdm_addr_map`

## Requirements
- R1: After a reset with `wdt_pd_rst` low, both bank pointers, the control register and all three memory pointers read 0. Zero is the default pointer reset value.
- R2: A bank pointer stores bits 2:0 of a write. Bits 7:3 always read as zero.
- R3: `acc_kind` 2 is the indirect port 1. It uses pointer 1 with bank pointer 1 when control bit 7 is 0, and pointer 2 with bank pointer 2 when that bit is 1. For an offset at or above 0x40, `ram_addr` = {bank[2:0], pointer}.
- R4: `acc_kind` 1 is the indirect port 0. It uses pointer 0 and gives bank bits 000 for any bank pointer value.
- R5: `acc_kind` 0 is a direct access. Its offset is `acc_addr` and its bank bits are always 000.
- R6: A resolved offset below 0x40 raises `sfr_hit`, gives `ram_addr` = {000, offset} for any bank value, and keeps `ram_we` low.
- R7: A reset taken while `wdt_pd_rst` is high leaves both bank pointers unchanged.
- R8: If the resolved offset is 0x00 or 0x02, the access writes no register, keeps `ram_we` low, and returns `own_hit` 0 and `own_rdata` 0.
- R9: `ram_we` is high exactly for a valid write whose resolved offset is 0x40 or more. A register write takes effect at the clock edge that ends the access. Within the access, `own_hit`/`own_rdata` show the register's value from before the write.
- R10: The control register stores bit 7 of a write. Bits 6:0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wdt_pd_rst | input | 1 | High while the reset comes from a watchdog time-out in power-down |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_kind | input | 2 | 0 direct, 1 indirect port 0, 2 indirect port 1 |
| acc_addr | input | 8 | Operand address (used by direct accesses) |
| acc_wdata | input | 8 | Write data |
| ram_addr | output | 11 | Physical RAM address {bank, offset} |
| ram_we | output | 1 | RAM write enable |
| sfr_hit | output | 1 | Resolved offset is in special-register space |
| own_hit | output | 1 | Access targets one of this block's registers |
| own_rdata | output | 8 | Read value of the targeted register, zero otherwise |

## Verification
Address resolution and a register update can land in the same cycle. A write through indirect port 1 can target bank pointer 2 while that same bank pointer drives the bank for the access. The bench provokes this by pointing pointer 2 at offset 0x06 and writing through the port. In that cycle it expects the outputs to show the old bank value. On the next access it expects the new bank to appear in `ram_addr`. A reset with the watchdog flag set, taken just after the bank pointers are loaded, checks that the pointers survive that reset while everything else clears.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  typedef enum logic [1:0] {
    ACC_DIRECT = 2'd0,
    ACC_IND0   = 2'd1,
    ACC_IND1   = 2'd2
  } acc_kind_e;

  localparam logic [7:0] IND0_OFS  = 8'h00;
  localparam logic [7:0] PTR0_OFS  = 8'h01;
  localparam logic [7:0] IND1_OFS  = 8'h02;
  localparam logic [7:0] PTR1_OFS  = 8'h03;
  localparam logic [7:0] PTR2_OFS  = 8'h04;
  localparam logic [7:0] BANK1_OFS = 8'h05;
  localparam logic [7:0] BANK2_OFS = 8'h06;
  localparam logic [7:0] CTRL_OFS  = 8'h07;

  localparam int unsigned NUM_PTR  = 3;
  localparam int unsigned NUM_BANK = 2;

  function automatic logic [7:0] ptr_ofs(input int unsigned idx);
    case (idx)
      0:       return PTR0_OFS;
      1:       return PTR1_OFS;
      default: return PTR2_OFS;
    endcase
  endfunction

  function automatic logic [7:0] bank_ofs(input int unsigned idx);
    return (idx == 0) ? BANK1_OFS : BANK2_OFS;
  endfunction
endpackage

// File: rtl/bdm_regfile.sv
module bdm_regfile
  import bdm_pkg::*;
#(
  parameter int unsigned OFS_W      = 8,
  parameter int unsigned BANK_W     = 3,
  parameter bit          MP_RST_EN  = 1'b1,
  parameter logic [7:0]  MP_RST_VAL = 8'h00
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wdt_pd_rst,
  input  logic                           wr_en,
  input  logic [OFS_W-1:0]               wr_ofs,
  input  logic [OFS_W-1:0]               wr_data,
  input  logic [OFS_W-1:0]               rd_ofs,
  output logic                           rd_hit,
  output logic [OFS_W-1:0]               rd_data,
  output logic [NUM_PTR-1:0][OFS_W-1:0]  ptr_o,
  output logic [NUM_BANK-1:0][BANK_W-1:0] bank_o,
  output logic                           sel_o
);
  localparam int unsigned PAD_W = OFS_W - BANK_W;

  // bank pointers only clear on a reset that is not a power-down watchdog reset
  logic bank_rst_n;
  assign bank_rst_n = rst_n | wdt_pd_rst;

  // memory pointers
  for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
    localparam logic [7:0] MY_OFS = ptr_ofs(p);
    logic [OFS_W-1:0] ptr_d, ptr_q;
    logic             ptr_en;

    always_comb begin
      ptr_en = wr_en && (wr_ofs == OFS_W'(MY_OFS));
      ptr_d  = ptr_en ? wr_data : ptr_q;
    end

    if (MP_RST_EN) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= OFS_W'(MP_RST_VAL);
        else        ptr_q <= ptr_d;
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        ptr_q <= ptr_d;
      end
    end

    assign ptr_o[p] = ptr_q;
  end

  // bank pointers
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    localparam logic [7:0] MY_OFS = bank_ofs(b);
    logic [BANK_W-1:0] bank_d, bank_q;
    logic              bank_en;

    always_comb begin
      bank_en = wr_en && (wr_ofs == OFS_W'(MY_OFS));
      bank_d  = bank_en ? wr_data[BANK_W-1:0] : bank_q;
    end

    always_ff @(posedge clk or negedge bank_rst_n) begin
      if (!bank_rst_n) bank_q <= '0;
      else             bank_q <= bank_d;
    end

    assign bank_o[b] = bank_q;
  end

  // pair select (control bit 7)
  logic sel_d, sel_q, sel_en;
  always_comb begin
    sel_en = wr_en && (wr_ofs == OFS_W'(CTRL_OFS));
    sel_d  = sel_en ? wr_data[OFS_W-1] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  // read mux
  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    case (rd_ofs)
      OFS_W'(PTR0_OFS):  rd_data = ptr_o[0];
      OFS_W'(PTR1_OFS):  rd_data = ptr_o[1];
      OFS_W'(PTR2_OFS):  rd_data = ptr_o[2];
      OFS_W'(BANK1_OFS): rd_data = {{PAD_W{1'b0}}, bank_o[0]};
      OFS_W'(BANK2_OFS): rd_data = {{PAD_W{1'b0}}, bank_o[1]};
      OFS_W'(CTRL_OFS):  rd_data = {sel_q, {(OFS_W-1){1'b0}}};
      default:           rd_hit  = 1'b0;
    endcase
  end
endmodule

// File: rtl/bdm_resolve.sv
module bdm_resolve
  import bdm_pkg::*;
#(
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned BANK_W = 3
) (
  input  logic [1:0]                      kind,
  input  logic [OFS_W-1:0]                addr,
  input  logic [NUM_PTR-1:0][OFS_W-1:0]   ptr,
  input  logic [NUM_BANK-1:0][BANK_W-1:0] bank,
  input  logic                            sel,
  output logic [OFS_W-1:0]                eff_ofs,
  output logic [BANK_W-1:0]               eff_bank,
  output logic                            is_null
);
  always_comb begin
    eff_ofs  = addr;
    eff_bank = '0;
    case (acc_kind_e'(kind))
      ACC_IND0: eff_ofs = ptr[0];
      ACC_IND1: begin
        eff_ofs  = sel ? ptr[2]  : ptr[1];
        eff_bank = sel ? bank[1] : bank[0];
      end
      default: ;
    endcase
    is_null = (eff_ofs == OFS_W'(IND0_OFS)) || (eff_ofs == OFS_W'(IND1_OFS));
  end
endmodule

// File: rtl/bdm_addr_map.sv
module bdm_addr_map
  import bdm_pkg::*;
#(
  parameter int unsigned OFS_W      = 8,
  parameter int unsigned BANK_W     = 3,
  parameter int unsigned SFR_LIMIT  = 'h40,
  parameter bit          MP_RST_EN  = 1'b1,
  parameter logic [7:0]  MP_RST_VAL = 8'h00,
  localparam int unsigned PHYS_W    = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_pd_rst,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [1:0]        acc_kind,
  input  logic [OFS_W-1:0]  acc_addr,
  input  logic [OFS_W-1:0]  acc_wdata,
  output logic [PHYS_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              sfr_hit,
  output logic              own_hit,
  output logic [OFS_W-1:0]  own_rdata
);
  logic [NUM_PTR-1:0][OFS_W-1:0]   ptr;
  logic [NUM_BANK-1:0][BANK_W-1:0] bank;
  logic                            sel;
  logic [OFS_W-1:0]                eff_ofs;
  logic [BANK_W-1:0]               eff_bank;
  logic                            is_null;
  logic                            reg_wr;
  logic                            rd_hit;
  logic [OFS_W-1:0]                rd_data;
  logic                            in_sfr;

  bdm_resolve #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_resolve (
    .kind     (acc_kind),
    .addr     (acc_addr),
    .ptr      (ptr),
    .bank     (bank),
    .sel      (sel),
    .eff_ofs  (eff_ofs),
    .eff_bank (eff_bank),
    .is_null  (is_null)
  );

  assign reg_wr = acc_valid && acc_we && !is_null;

  bdm_regfile #(
    .OFS_W      (OFS_W),
    .BANK_W     (BANK_W),
    .MP_RST_EN  (MP_RST_EN),
    .MP_RST_VAL (MP_RST_VAL)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdt_pd_rst (wdt_pd_rst),
    .wr_en      (reg_wr),
    .wr_ofs     (eff_ofs),
    .wr_data    (acc_wdata),
    .rd_ofs     (eff_ofs),
    .rd_hit     (rd_hit),
    .rd_data    (rd_data),
    .ptr_o      (ptr),
    .bank_o     (bank),
    .sel_o      (sel)
  );

  always_comb begin
    in_sfr    = (32'(eff_ofs) < SFR_LIMIT);
    sfr_hit   = acc_valid && in_sfr;
    ram_addr  = in_sfr ? {{BANK_W{1'b0}}, eff_ofs} : {eff_bank, eff_ofs};
    ram_we    = acc_valid && acc_we && !in_sfr && !is_null;
    own_hit   = acc_valid && rd_hit && !is_null;
    own_rdata = own_hit ? rd_data : '0;
  end
endmodule

// File: rtl/bdm_addr_map_chk.sv
module bdm_addr_map_chk #(
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned SFR_LIMIT = 'h40
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_valid,
  input logic                    acc_we,
  input logic [1:0]              acc_kind,
  input logic [OFS_W-1:0]        acc_addr,
  input logic [BANK_W+OFS_W-1:0] ram_addr,
  input logic                    ram_we,
  input logic                    sfr_hit,
  input logic                    own_hit,
  input logic [OFS_W-1:0]        own_rdata
);
  localparam int unsigned PHYS_W = BANK_W + OFS_W;

  // R4
  ind0_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd1) |-> (ram_addr[PHYS_W-1:OFS_W] == '0));

  // R5
  direct_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd0) |-> (ram_addr == {{BANK_W{1'b0}}, acc_addr}));

  // R6
  sfr_unbanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_hit |-> (ram_addr[PHYS_W-1:OFS_W] == '0 && !ram_we));

  // R9
  we_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (acc_valid && acc_we && !sfr_hit));

  // R2
  bank_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd0 && (acc_addr == 8'h05 || acc_addr == 8'h06))
      |-> (own_hit && own_rdata[OFS_W-1:BANK_W] == '0));

  // R10
  ctrl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd0 && acc_addr == 8'h07)
      |-> (own_rdata[OFS_W-2:0] == '0));

  // R8
  null_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'd0 && (acc_addr == 8'h00 || acc_addr == 8'h02))
      |-> (!own_hit && own_rdata == '0 && !ram_we));
endmodule

bind bdm_addr_map bdm_addr_map_chk #(
  .OFS_W     (OFS_W),
  .BANK_W    (BANK_W),
  .SFR_LIMIT (SFR_LIMIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_we    (acc_we),
  .acc_kind  (acc_kind),
  .acc_addr  (acc_addr),
  .ram_addr  (ram_addr),
  .ram_we    (ram_we),
  .sfr_hit   (sfr_hit),
  .own_hit   (own_hit),
  .own_rdata (own_rdata)
);

// File: tb/bdm_addr_map_test.sv
module bdm_addr_map_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdt_pd_rst = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_we = 1'b0;
  logic [1:0]  acc_kind = 2'd0;
  logic [7:0]  acc_addr = 8'h00;
  logic [7:0]  acc_wdata = 8'h00;
  logic [10:0] ram_addr;
  logic        ram_we;
  logic        sfr_hit;
  logic        own_hit;
  logic [7:0]  own_rdata;

  always #4 clk = ~clk;

  bdm_addr_map uut (
    .clk(clk), .rst_n(rst_n), .wdt_pd_rst(wdt_pd_rst),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .ram_addr(ram_addr), .ram_we(ram_we), .sfr_hit(sfr_hit),
    .own_hit(own_hit), .own_rdata(own_rdata)
  );

  typedef struct packed {
    logic [10:0] addr;
    logic        we;
    logic        sfr;
    logic        hit;
    logic [7:0]  rd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_tests = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // reference state, kept from the requirements
  logic [7:0] m_ptr0, m_ptr1, m_ptr2, m_ctrl;
  logic [2:0] m_bk1, m_bk2;

  function automatic logic [7:0] m_read(input logic [7:0] o);
    case (o)
      8'h01: return m_ptr0;
      8'h03: return m_ptr1;
      8'h04: return m_ptr2;
      8'h05: return {5'b0, m_bk1};
      8'h06: return {5'b0, m_bk2};
      8'h07: return m_ctrl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic acc(input logic [1:0] k, input logic [7:0] a, input logic we,
                     input logic [7:0] d, input string tag);
    logic [7:0] o;
    logic [2:0] b;
    logic       nul, sfr, hit;
    exp_t       e;
    o = a; b = 3'd0;
    if (k == 2'd1) o = m_ptr0;
    if (k == 2'd2) begin
      o = m_ctrl[7] ? m_ptr2 : m_ptr1;
      b = m_ctrl[7] ? m_bk2 : m_bk1;
    end
    nul = (o == 8'h00) || (o == 8'h02);
    sfr = (o < 8'h40);
    hit = !nul && (o == 8'h01 || (o >= 8'h03 && o <= 8'h07));
    e.addr = sfr ? {3'b000, o} : {b, o};
    e.we   = we && !sfr && !nul;
    e.sfr  = sfr;
    e.hit  = hit;
    e.rd   = hit ? m_read(o) : 8'h00;
    @(negedge clk);
    acc_valid = 1'b1; acc_we = we; acc_kind = k; acc_addr = a; acc_wdata = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (we && !nul) begin
      case (o)
        8'h01: m_ptr0 = d;
        8'h03: m_ptr1 = d;
        8'h04: m_ptr2 = d;
        8'h05: m_bk1 = d[2:0];
        8'h06: m_bk2 = d[2:0];
        8'h07: m_ctrl = {d[7], 7'b0};
        default: ;
      endcase
    end
  endtask

  task automatic do_reset(input logic wdt);
    @(negedge clk);
    acc_valid = 1'b0;
    wdt_pd_rst = wdt;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wdt_pd_rst = 1'b0;
    m_ptr0 = 8'h00; m_ptr1 = 8'h00; m_ptr2 = 8'h00; m_ctrl = 8'h00;
    if (!wdt) begin m_bk1 = 3'd0; m_bk2 = 3'd0; end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (exp_q.size() != 0) begin
        exp_t  e;
        exp_t  act;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = {ram_addr, ram_we, sfr_hit, own_hit, own_rdata};
        n_tests++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s: actual addr=%h we=%b sfr=%b hit=%b rd=%h expected addr=%h we=%b sfr=%b hit=%b rd=%h",
                   t, act.addr, act.we, act.sfr, act.hit, act.rd,
                   e.addr, e.we, e.sfr, e.hit, e.rd);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_bk1 = 3'd0; m_bk2 = 3'd0;
    do_reset(1'b0);
    // R1 reset state
    acc(2'd0, 8'h05, 1'b0, 8'h00, "R1 bank1 reset");
    acc(2'd0, 8'h06, 1'b0, 8'h00, "R1 bank2 reset");
    acc(2'd0, 8'h07, 1'b0, 8'h00, "R1 ctrl reset");
    acc(2'd0, 8'h03, 1'b0, 8'h00, "R1 ptr1 reset");
    // R2 bank pointer fields
    acc(2'd0, 8'h05, 1'b1, 8'hFF, "R2 bank1 write");
    acc(2'd0, 8'h05, 1'b0, 8'h00, "R2 bank1 readback");
    acc(2'd0, 8'h06, 1'b1, 8'hFB, "R2 bank2 write");
    acc(2'd0, 8'h06, 1'b0, 8'h00, "R2 bank2 readback");
    // R3 pair selection
    acc(2'd0, 8'h03, 1'b1, 8'h80, "R3 ptr1 load");
    acc(2'd0, 8'h04, 1'b1, 8'h45, "R3 ptr2 load");
    acc(2'd2, 8'h00, 1'b0, 8'h00, "R3 pair1 read");
    acc(2'd0, 8'h07, 1'b1, 8'hFF, "R10 ctrl write");
    acc(2'd0, 8'h07, 1'b0, 8'h00, "R10 ctrl readback");
    acc(2'd2, 8'h00, 1'b0, 8'h00, "R3 pair2 read");
    acc(2'd2, 8'h00, 1'b1, 8'h5A, "R9 pair2 ram write");
    // R4 indirect port 0 stays in bank 0
    acc(2'd0, 8'h01, 1'b1, 8'h90, "R4 ptr0 load");
    acc(2'd1, 8'h00, 1'b1, 8'h11, "R4 ind0 write");
    // R5 direct stays in bank 0
    acc(2'd0, 8'h55, 1'b1, 8'h22, "R5 direct write");
    acc(2'd0, 8'hFF, 1'b0, 8'h00, "R5 direct read top");
    // R6 special region ignores banking
    acc(2'd0, 8'h04, 1'b1, 8'h20, "R6 ptr2 to sfr");
    acc(2'd2, 8'h00, 1'b1, 8'h33, "R6 sfr write via ind1");
    acc(2'd0, 8'h3F, 1'b1, 8'h33, "R6 sfr boundary");
    acc(2'd0, 8'h40, 1'b1, 8'h33, "R9 first ram offset");
    // R8 indirect register as target
    acc(2'd0, 8'h04, 1'b1, 8'h02, "R8 ptr2 to ind1");
    acc(2'd2, 8'h00, 1'b1, 8'h77, "R8 null write");
    acc(2'd0, 8'h04, 1'b0, 8'h00, "R8 ptr2 unchanged");
    acc(2'd0, 8'h01, 1'b1, 8'h00, "R8 ptr0 to ind0");
    acc(2'd1, 8'h00, 1'b0, 8'h00, "R8 null read");
    acc(2'd1, 8'h00, 1'b1, 8'h66, "R8 null write ind0");
    acc(2'd0, 8'h01, 1'b0, 8'h00, "R8 ptr0 unchanged");
    // R9 same-cycle resolve and register update
    acc(2'd0, 8'h04, 1'b1, 8'h06, "R9 ptr2 to bank2");
    acc(2'd2, 8'h00, 1'b1, 8'h05, "R9 write bank2 via ind1");
    acc(2'd0, 8'h04, 1'b1, 8'h50, "R3 ptr2 to ram");
    acc(2'd2, 8'h00, 1'b0, 8'h00, "R3 new bank2 used");
    // R7 watchdog power-down reset keeps banks
    do_reset(1'b1);
    acc(2'd0, 8'h05, 1'b0, 8'h00, "R7 bank1 kept");
    acc(2'd0, 8'h06, 1'b0, 8'h00, "R7 bank2 kept");
    acc(2'd0, 8'h07, 1'b0, 8'h00, "R1 ctrl cleared");
    acc(2'd0, 8'h04, 1'b0, 8'h00, "R1 ptr2 cleared");
    do_reset(1'b0);
    acc(2'd0, 8'h05, 1'b0, 8'h00, "R1 bank1 cleared");
    acc(2'd0, 8'h06, 1'b0, 8'h00, "R1 bank2 cleared");
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule